// File: doc/BRIEF.md
# SDRAM Burst Column Address Sequencer

This block produces the column address stream for one SDRAM read or write burst. A configuration word is captured on a load strobe. The block decodes that word into a burst length and an ordering, and it also holds a write policy. A start strobe then supplies a 9-bit start column. From the next clock on, the block presents one column per cycle, with a valid flag and a flag that marks the final beat.

The burst can be 1, 2, 4 or 8 beats long, or it can be a full page. In the full-page case, addresses advance sequentially through all 512 columns and wrap. A full-page burst runs until the terminate input is seen. A policy bit can force every write to a single beat while reads keep the programmed length. Length codes that are not defined, and a full page requested with interleaved ordering, both fall back to a single beat.

Top module: `sdram_col_seq`

## Requirements
- R1: During and right after reset, `col_valid` and `col_last` are 0.
- R2: Configuration bits [2:0] select the length: 000 gives 1 beat, 001 gives 2, 010 gives 4, 011 gives 8, and 111 gives a full page. The burst shows exactly that many valid beats.
- R3: With bit [3]=0 (sequential) and length N of 8 or less, the column bits above log2(N) keep the start value. The low bits count up from the start value modulo N.
- R4: With bit [3]=1 (interleaved) and length N, beat k carries (start low bits XOR k) in its low log2(N) bits. The upper bits keep the start value.
- R5: A full-page burst increments the column by one per beat modulo 512. It runs until `terminate` is sampled high, and `col_last` is high on that same beat.
- R6: Codes 100, 101 and 110, and code 111 together with bit [3]=1, all produce a 1-beat burst.
- R7: With bit [9]=1, a burst started with `is_write`=1 is a single beat. Read bursts still use the programmed length.
- R8: The first beat appears on the cycle after `start` and carries `start_col`. Each following cycle carries one more beat.
- R9: A `start` during a burst is ignored unless it arrives on the last beat. On the last beat it begins the next burst with no gap.
- R10: A configuration load during a burst leaves that burst unchanged. The next burst uses the new configuration.
- R11: `terminate` has no effect on fixed-length bursts or when no burst is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Captures `cfg_word` |
| cfg_word | input | 10 | Configuration word (length, ordering, write policy) |
| start | input | 1 | Begins a burst at `start_col` |
| start_col | input | 9 | First column of the burst |
| is_write | input | 1 | The burst being started is a write |
| terminate | input | 1 | Ends a full-page burst on the current beat |
| col | output | 9 | Current column address |
| col_valid | output | 1 | `col` carries a burst beat |
| col_last | output | 1 | Current beat is the last of the burst |

## Verification
The assertions assume that `start`, `is_write` and `start_col` are sampled only when the block is idle or on a last beat. They also assume that `terminate` means something only during a full-page burst. The block-boundary and page-step properties rely on this. The stimulus drives every input at the falling edge and so keeps each value stable across the sampling edge. On purpose, it also raises `start` and `terminate` at moments the block must ignore, which checks that those moments leave the column stream untouched.

// File: rtl/sdram_col_seq.sv
module sdram_col_seq #(
  parameter int COL_W  = 9,
  parameter int CFG_W  = 10,
  parameter int TYPE_B = 3,
  parameter int WPOL_B = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_load,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic             is_write,
  input  logic             terminate,
  output logic [COL_W-1:0] col,
  output logic             col_valid,
  output logic             col_last
);

  localparam logic [COL_W-1:0] PAGE_MASK = {COL_W{1'b1}};

  logic [2:0]       len_q;
  logic             ilv_cfg_q;
  logic             wone_q;

  logic             act_q;
  logic             full_q;
  logic             ilv_q;
  logic [COL_W-1:0] base_q;
  logic [COL_W-1:0] beat_q;
  logic [COL_W-1:0] mask_q;

  logic [COL_W-1:0] mask_d;
  logic             full_d;
  logic             done;
  logic             take;
  logic [COL_W-1:0] low;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      len_q     <= '0;
      ilv_cfg_q <= 1'b0;
      wone_q    <= 1'b0;
    end else if (cfg_load) begin
      len_q     <= cfg_word[2:0];
      ilv_cfg_q <= cfg_word[TYPE_B];
      wone_q    <= cfg_word[WPOL_B];
    end

  always_comb begin
    full_d = 1'b0;
    case (len_q)
      3'b000:  mask_d = COL_W'(0);
      3'b001:  mask_d = COL_W'(1);
      3'b010:  mask_d = COL_W'(3);
      3'b011:  mask_d = COL_W'(7);
      3'b111:  begin
        full_d = !ilv_cfg_q;
        mask_d = ilv_cfg_q ? COL_W'(0) : PAGE_MASK;
      end
      default: mask_d = COL_W'(0);
    endcase
    if (is_write && wone_q) begin
      full_d = 1'b0;
      mask_d = COL_W'(0);
    end
  end

  assign done = act_q && (full_q ? terminate : (beat_q == mask_q));
  assign take = start && (!act_q || done);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      act_q  <= 1'b0;
      full_q <= 1'b0;
      ilv_q  <= 1'b0;
      base_q <= '0;
      beat_q <= '0;
      mask_q <= '0;
    end else if (take) begin
      act_q  <= 1'b1;
      full_q <= full_d;
      ilv_q  <= ilv_cfg_q && !full_d;
      base_q <= start_col;
      beat_q <= '0;
      mask_q <= mask_d;
    end else if (done) begin
      act_q  <= 1'b0;
    end else if (act_q) begin
      beat_q <= beat_q + 1'b1;
    end

  assign low       = ilv_q ? (base_q ^ beat_q) : (base_q + beat_q);
  assign col       = (base_q & ~mask_q) | (low & mask_q);
  assign col_valid = act_q;
  assign col_last  = done;

endmodule

module sdram_col_seq_chk #(
  parameter int COL_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             is_write,
  input logic             wone,
  input logic             full,
  input logic [COL_W-1:0] col,
  input logic             col_valid,
  input logic             col_last
);

  p_last_in_burst_r8: assert property (@(posedge clk) disable iff (!rst_n)
    col_last |-> col_valid);

  p_begin_on_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(col_valid) |-> $past(start));

  p_stop_after_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (col_last && !start) |=> !col_valid);

  p_single_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && (!col_valid || col_last) && is_write && wone) |=> col_last);

  p_block_fixed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && !col_last && !full) |=> (col[COL_W-1:3] == $past(col[COL_W-1:3])));

  p_page_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && !col_last && full) |=> (col == COL_W'($past(col) + 1'b1)));

endmodule

bind sdram_col_seq sdram_col_seq_chk #(.COL_W(COL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .is_write(is_write),
  .wone(wone_q), .full(full_q), .col(col), .col_valid(col_valid),
  .col_last(col_last)
);

// File: tb/sdram_col_seq_bench.sv
module sdram_col_seq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_load = 1'b0;
  logic [9:0] cfg_word = '0;
  logic       start = 1'b0;
  logic [8:0] start_col = '0;
  logic       is_write = 1'b0;
  logic       terminate = 1'b0;
  logic [8:0] col;
  logic       col_valid, col_last;

  int n_chk = 0, n_fail = 0;
  string tag = "R1";
  bit finished = 0;

  always #4 clk = ~clk;

  sdram_col_seq u_sdram_col_seq (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_word(cfg_word),
    .start(start), .start_col(start_col), .is_write(is_write),
    .terminate(terminate), .col(col), .col_valid(col_valid), .col_last(col_last)
  );

  int m_cfg = 0, m_act = 0, m_beat = 0, m_n = 1, m_full = 0, m_ilv = 0, m_s = 0;

  function automatic int exp_last();
    if (m_act == 0) return 0;
    if (m_full != 0) return int'(terminate);
    return (m_beat == m_n - 1) ? 1 : 0;
  endfunction

  function automatic int exp_col();
    int n, lo;
    n  = (m_full != 0) ? 512 : m_n;
    lo = (m_ilv != 0) ? ((m_s % n) ^ (m_beat % n)) : ((m_s + m_beat) % n);
    return (m_s - (m_s % n)) + lo;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cfg = 0; m_act = 0; m_beat = 0;
    end else begin
      int lst;
      lst = exp_last();
      if (m_act != 0 && lst == 0) m_beat++;
      else if (start) begin
        int code;
        code = m_cfg & 7;
        m_act = 1; m_beat = 0; m_s = int'(start_col); m_full = 0;
        m_ilv = (m_cfg >> 3) & 1;
        case (code)
          1: m_n = 2;
          2: m_n = 4;
          3: m_n = 8;
          7: begin m_n = 1; m_full = (m_ilv == 0) ? 1 : 0; end
          default: m_n = 1;
        endcase
        if (is_write && ((m_cfg >> 9) & 1) != 0) begin m_n = 1; m_full = 0; end
      end else m_act = 0;
      if (cfg_load) m_cfg = int'(cfg_word);
    end
  end

  task automatic chk(input int act, input int exp, input string what);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic tick(input bit st, input int sc, input bit wr, input bit tm,
                      input bit ld, input int mw);
    @(negedge clk);
    start = st; start_col = 9'(sc); is_write = wr; terminate = tm;
    cfg_load = ld; cfg_word = 10'(mw);
    #1;
    chk(int'(col_valid), m_act, "col_valid");
    chk(int'(col_last), exp_last(), "col_last");
    if (m_act != 0) chk(int'(col), exp_col(), "col");
  endtask

  task automatic load(input int mw); tick(0, 0, 0, 0, 1, mw); endtask
  task automatic go(input int c, input bit wr); tick(1, c, wr, 0, 0, 0); endtask
  task automatic idle(input int n, input bit tm);
    for (int i = 0; i < n; i++) tick(0, 0, 0, tm, 0, 0);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    tag = "R1";
    repeat (3) @(negedge clk);
    chk(int'(col_valid), 0, "reset col_valid");
    chk(int'(col_last), 0, "reset col_last");
    rst_n = 1'b1;
    idle(2, 0);

    tag = "R2"; load('h000); go(5, 0); idle(3, 0);
    tag = "R3"; load('h001); go('h1F5, 0); idle(3, 0);
    load('h002); go('h1F5, 0); idle(5, 0);
    load('h003); go('h1F5, 0); idle(9, 0);
    go('h0A8, 0); idle(9, 0);

    tag = "R4"; load('h00B); go('h00D, 0); idle(9, 0);
    load('h00A); go('h1F6, 0); idle(5, 0);
    load('h009); go('h033, 0); idle(3, 0);

    tag = "R5"; load('h007); go('h1FE, 0); idle(5, 0); tick(0, 0, 0, 1, 0, 0); idle(2, 0);
    go('h010, 0); tick(0, 0, 0, 1, 0, 0); idle(2, 0);
    go('h100, 0); idle(520, 0); tick(0, 0, 0, 1, 0, 0); idle(2, 0);

    tag = "R6"; load('h00F); go('h044, 0); idle(3, 0);
    load('h004); go('h045, 0); idle(3, 0);
    load('h005); go('h046, 0); idle(3, 0);
    load('h006); go('h047, 0); idle(3, 0);

    tag = "R7"; load('h202); go('h020, 1); idle(3, 0);
    go('h020, 0); idle(5, 0);
    load('h207); go('h1FF, 1); idle(3, 0);
    load('h002); go('h021, 1); idle(5, 0);

    tag = "R8"; load('h003); go('h077, 0); idle(9, 0);

    tag = "R9"; go('h010, 0); idle(2, 0); go('h0F0, 0); idle(7, 0);
    load('h002); go('h030, 0); idle(2, 0); go('h048, 0); idle(2, 0); go('h0C1, 1); idle(5, 0);

    tag = "R10"; load('h003); go('h050, 0); idle(2, 0); load('h001); idle(6, 0);
    go('h052, 0); idle(3, 0);

    tag = "R11"; load('h002); go('h060, 0); idle(2, 1); idle(3, 0);
    idle(3, 1); idle(1, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule